// File: doc/BRIEF.md
# CPU Bus Phase Generator

This block turns a fast clock, running at twice the master oscillator rate, into the two-phase timing of a CPU bus cycle. One bus cycle lasts twelve master cycles, which is twenty-four ticks of the fast clock. Because the block counts half master cycles, it can place the edges of the bus qualifier M2 on master half-cycles. M2 is therefore not a square wave. It is low for 4.5 master cycles and high for 7.5 master cycles, so it is high for five eighths of each bus cycle. At the nominal rate this is about 210 ns low and about 349 ns high.

Bus logic elsewhere uses four outputs. The `m2` level is the qualifier itself. The `in_phi2` level tells which phase is current. Two one-tick strobes mark the first fast cycle of each phase: `phi1_start` and `phi2_start`. A synchronous reset restarts the bus cycle at its first tick, with M2 low.

Top module: `cpu_phase_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to tick 0. While `rst` is high, `m2`, `in_phi2`, `phi1_start` and `phi2_start` are all 0.
- R2: After reset is released, the tick sequence repeats every 24 fast clock cycles, which is 12 master cycles. The first cycle with `rst` low is tick 0.
- R3: `m2` is 0 on ticks 0 to 8 and 1 on ticks 9 to 23. This gives runs of 9 low cycles and 15 high cycles.
- R4: `in_phi2` is 1 exactly when `m2` is 1, and 0 during phi1.
- R5: `phi1_start` is 1 for the single fast cycle of tick 0 in each bus cycle, and 0 otherwise.
- R6: `phi2_start` is 1 for the single fast cycle of tick 9, which is the first cycle in which `m2` is high. It is 0 otherwise.
- R7: `phi1_start` and `phi2_start` are never 1 in the same cycle.
- R8: A reset applied in the middle of a bus cycle, during either phase, discards the partial cycle. The sequence restarts at tick 0 after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock at twice the master oscillator rate |
| rst | input | 1 | Synchronous reset, active high |
| m2 | output | 1 | Bus qualifier, high for 15 of 24 ticks |
| in_phi2 | output | 1 | Phase indicator: 1 during phi2, 0 during phi1 |
| phi1_start | output | 1 | One-tick strobe on tick 0 |
| phi2_start | output | 1 | One-tick strobe on tick 9 |

## Verification
The tick counter is the only register. A change on `rst` takes effect at the next rising edge, and all four outputs follow in the same cycle through combinational decode. The strobes are also gated by `rst` directly. The bench changes `rst` just after a rising edge and samples every output at the falling edge of each cycle. At that point it compares them with a reference that counts cycles since release. The bench also measures each completed low and high run of `m2` against 9 and 15 ticks. It applies reset once during phi1 and once during phi2 to check the restart.

// File: rtl/cpu_phase_gen.sv
module cpu_phase_gen #(
  parameter int TICKS_PER_CYCLE = 24,
  parameter int LOW_TICKS       = 9
) (
  input  logic clk,
  input  logic rst,
  output logic m2,
  output logic in_phi2,
  output logic phi1_start,
  output logic phi2_start
);

  localparam int CW = $clog2(TICKS_PER_CYCLE);
  localparam logic [CW-1:0] LAST_TICK = CW'(TICKS_PER_CYCLE - 1);
  localparam logic [CW-1:0] RISE_TICK = CW'(LOW_TICKS);

  logic [CW-1:0] tick;

  always_ff @(posedge clk) begin
    if (rst)                 tick <= '0;
    else if (tick == LAST_TICK) tick <= '0;
    else                     tick <= tick + 1'b1;
  end

  assign m2         = !rst && (tick >= RISE_TICK);
  assign in_phi2    = m2;
  assign phi1_start = !rst && (tick == '0);
  assign phi2_start = !rst && (tick == RISE_TICK);

  // R1: reset returns the counter to tick 0
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (tick == '0));

  // R2: the last tick is followed by tick 0
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick == LAST_TICK) |=> (tick == '0));

  // R3: m2 stays high until the end of the bus cycle
  a_r3_high_holds: assert property (@(posedge clk) disable iff (rst)
    (m2 && tick != LAST_TICK) |=> m2);

  // R6: the phi2 strobe marks a rising edge of m2
  a_r6_phi2_on_rise: assert property (@(posedge clk) disable iff (rst)
    phi2_start |-> (m2 && !$past(m2)));

  // R7: the two strobes never coincide
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(phi1_start && phi2_start));

endmodule

// File: tb/cpu_phase_gen_test.sv
module cpu_phase_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS = 24;
  localparam int LOWT  = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m2, in_phi2, phi1_start, phi2_start;

  int checks = 0;
  int errors = 0;
  int since = 0;
  int run = 0;
  logic last_m2 = 1'b0;
  bit done = 1'b0;

  cpu_phase_gen uut (
    .clk(clk), .rst(rst), .m2(m2), .in_phi2(in_phi2),
    .phi1_start(phi1_start), .phi2_start(phi2_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) since <= 0;
    else     since <= since + 1;
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int ph;
    ph = since % TICKS;
    if (rst) begin
      check("R1 m2", m2, 1'b0);
      check("R1 in_phi2", in_phi2, 1'b0);
      check("R1 phi1_start", phi1_start, 1'b0);
      check("R1 phi2_start", phi2_start, 1'b0);
      run = 0;
      last_m2 = 1'b0;
    end else begin
      check("R3 m2", m2, ph >= LOWT);
      check("R4 in_phi2", in_phi2, ph >= LOWT);
      check("R5 phi1_start", phi1_start, ph == 0);
      check("R6 phi2_start", phi2_start, ph == LOWT);
      check("R7 exclusive", phi1_start & phi2_start, 1'b0);
      if (m2 === last_m2) run++;
      else begin
        checks++;
        if (run != (last_m2 ? TICKS - LOWT : LOWT)) begin
          errors++;
          $display("FAIL R2 run length of m2=%b: actual %0d expected %0d",
                   last_m2, run, last_m2 ? TICKS - LOWT : LOWT);
        end
        run = 1;
        last_m2 = m2;
      end
    end
  end

  task automatic go(input logic r, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1 rst = r;
    end
  endtask

  initial begin
    go(1'b1, 3);
    go(1'b0, 5 * TICKS + 3);   // R2, R3: several full bus cycles
    go(1'b1, 2);               // R8: reset during phi1 (tick 3)
    go(1'b0, 2 * TICKS + 14);
    go(1'b1, 1);               // R8: reset during phi2
    go(1'b0, 3 * TICKS);
    go(1'b0, 2);
    done = 1'b1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 200000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule